// File: doc/BRIEF.md
# IMA Transmit Stuff Scheduler

This block decides, for every transmit link of an inverse-multiplexed ATM group, in which IMA frame the link inserts its stuff cell, and raises the matching advance indication flag carried by the control cell of the preceding frames. Each link has its own cell strobe and frame-boundary strobe. Every output is registered and changes only on that link's frame strobe. It holds for the whole frame, so the framer can sample it at any point while it builds the frame.

A per-link cell counter of `CNT_W` bits defines the stuff period. The period is 2^`CNT_W` cells, which is 2048 at the default. The reference link always stuffs in the frame that holds its counter wrap. In fixed mode, every other link copies the reference link's schedule cycle for cycle. The frame strobes of a group are expected to be cycle-aligned. In the two adaptive modes, each non-reference link compares its transmit FIFO fill with the reference link's fill. If its fill is too high, it skips a stuff. If its fill is too low, it stuffs early.

A stuff is always committed four frames ahead of time. The indication is then raised either in all four frames before the stuff or only in the last one.

Top module: `ima_stuff_sched`

## Requirements
- R1: While `rst_ni` is low, and until a link's first frame strobe after reset, that link's `stuff_o` and `ind_o` are 0 and its cell strobes are not counted. The first frame strobe itself produces no stuff or indication.
- R2: The reference link stuffs exactly once per 2^`CNT_W` counted cells. It is scheduled at the first frame strobe at which its count is at least 2^`CNT_W` − 5·`FRAME_CELLS`. When frames carry exactly `FRAME_CELLS` cells, the stuff therefore lands in the frame that contains the counter wrap.
- R3: A stuff scheduled at frame strobe k sets `stuff_o` for the frame starting at strobe k+4 only. `stuff_o` and `ind_o` are never high together on one link.
- R4: With `ind4_i`=1, `ind_o` is high for the frames starting at strobes k..k+3. With `ind4_i`=0, it is high only for the frame starting at strobe k+3.
- R5: `stuff_o[i]` and `ind_o[i]` change only in the cycle after `frame_i[i]` is high.
- R6: `mode_i` encoding: 0 = CTC fixed, 1 = CTC adaptive, 2 = ITC adaptive, 3 = fixed. In fixed mode, a non-reference link schedules in the same cycle as the reference link, whatever its own count or FIFO level.
- R7: In an adaptive mode, a non-reference link whose level exceeds the reference level by more than `THRESH` when its scheduling point is reached skips the stuff for that period. A difference of exactly `THRESH` does not skip.
- R8: In an adaptive mode, a non-reference link that is idle, has not yet scheduled or skipped in the current period, and whose level is more than `THRESH` below the reference level schedules at that frame strobe. Each counter wrap starts a new period.
- R9: Once a stuff is scheduled, later level or mode changes do not cancel it or move it.
- R10: `ref_sel_i` selects the reference link. Link i's fill level is the unsigned field `lvl_i[i*LVL_W +: LVL_W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cell_i | input | N_LINKS | Per-link cell-boundary strobe |
| frame_i | input | N_LINKS | Per-link IMA frame-boundary strobe |
| mode_i | input | 2 | Stuff policy select (R6 encoding) |
| ind4_i | input | 1 | 1: four indication frames, 0: one |
| ref_sel_i | input | REF_W | Reference link index |
| lvl_i | input | N_LINKS*LVL_W | Packed per-link transmit FIFO fill levels |
| stuff_o | output | N_LINKS | Current frame carries a stuff event |
| ind_o | output | N_LINKS | Current frame's control cell carries the stuff indication |

## Verification
The bench builds the block with `CNT_W`=6 and `FRAME_CELLS`=4, so one stuff period is 64 cells or 16 frames and the scheduling point falls at count 44. Every scenario covers two full periods and the start of a third, within a few hundred clocks. With `LVL_W`=8 and `THRESH`=5, the levels can be placed exactly on the threshold and one step beyond it on either side. One link is given no cell strobes at all, to show that in fixed mode it follows the reference link regardless of its own count.

// File: rtl/ima_stuff_pkg.sv
package ima_stuff_pkg;
  typedef enum logic [1:0] {
    MODE_CTC_FIX = 2'd0,
    MODE_CTC_ADP = 2'd1,
    MODE_ITC_ADP = 2'd2,
    MODE_FIX_ALT = 2'd3
  } stuff_mode_e;

  localparam int unsigned LEAD_FRAMES = 4;
  localparam int unsigned CD_W        = 3;
endpackage

// File: rtl/ima_stuff_cell_ctr.sv
module ima_stuff_cell_ctr #(
  parameter int unsigned CNT_W    = 11,
  parameter int unsigned SCHED_PT = 1408
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_i,
  input  logic cell_i,
  output logic live_o,
  output logic wrap_o,
  output logic due_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] PT      = CNT_W'(SCHED_PT);

  logic [CNT_W-1:0] cnt_q;
  logic             live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      live_q <= 1'b0;
    end else begin
      if (frame_i) live_q <= 1'b1;
      if (live_q && cell_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign live_o = live_q;
  assign wrap_o = live_q & cell_i & (cnt_q == CNT_MAX);
  assign due_o  = (cnt_q >= PT);
endmodule

// File: rtl/ima_stuff_policy.sv
module ima_stuff_policy #(
  parameter int unsigned LVL_W  = 10,
  parameter int unsigned THRESH = 8
) (
  input  logic [LVL_W-1:0] own_lvl_i,
  input  logic [LVL_W-1:0] ref_lvl_i,
  input  logic             adaptive_i,
  input  logic             is_ref_i,
  output logic             hi_o,
  output logic             lo_o
);
  localparam int unsigned DW = LVL_W + 2;
  localparam logic signed [DW-1:0] TH_P = DW'(THRESH);
  localparam logic signed [DW-1:0] TH_N = -TH_P;

  logic signed [DW-1:0] diff;

  assign diff = $signed({2'b00, own_lvl_i}) - $signed({2'b00, ref_lvl_i});
  assign hi_o = adaptive_i & ~is_ref_i & (diff > TH_P);
  assign lo_o = adaptive_i & ~is_ref_i & (diff < TH_N);
endmodule

// File: rtl/ima_stuff_lookahead.sv
module ima_stuff_lookahead
  import ima_stuff_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_i,
  input  logic live_i,
  input  logic load_i,
  input  logic ind4_i,
  output logic busy_o,
  output logic stuff_o,
  output logic ind_o
);
  localparam logic [CD_W-1:0] LEAD_V = CD_W'(LEAD_FRAMES);
  localparam logic [CD_W-1:0] ONE_V  = CD_W'(1);

  logic [CD_W-1:0] cd_q, cd_nxt;
  logic            stuff_q, ind_q, ind_win;

  always_comb begin
    if (load_i)           cd_nxt = LEAD_V;
    else if (cd_q != '0)  cd_nxt = cd_q - 1'b1;
    else                  cd_nxt = '0;
    ind_win = (cd_nxt != '0) && (ind4_i ? (cd_nxt <= LEAD_V) : (cd_nxt == ONE_V));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cd_q    <= '0;
      stuff_q <= 1'b0;
      ind_q   <= 1'b0;
    end else if (frame_i) begin
      if (live_i) begin
        cd_q    <= cd_nxt;
        stuff_q <= !load_i && (cd_q == ONE_V);
        ind_q   <= ind_win;
      end else begin
        stuff_q <= 1'b0;
        ind_q   <= 1'b0;
      end
    end
  end

  assign busy_o  = (cd_q != '0);
  assign stuff_o = stuff_q;
  assign ind_o   = ind_q;
endmodule

// File: rtl/ima_stuff_sched.sv
module ima_stuff_sched
  import ima_stuff_pkg::*;
#(
  parameter int unsigned N_LINKS     = 4,
  parameter int unsigned CNT_W       = 11,
  parameter int unsigned FRAME_CELLS = 128,
  parameter int unsigned LVL_W       = 10,
  parameter int unsigned THRESH      = 8,
  localparam int unsigned REF_W      = (N_LINKS > 1) ? $clog2(N_LINKS) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_LINKS-1:0]       cell_i,
  input  logic [N_LINKS-1:0]       frame_i,
  input  logic [1:0]               mode_i,
  input  logic                     ind4_i,
  input  logic [REF_W-1:0]         ref_sel_i,
  input  logic [N_LINKS*LVL_W-1:0] lvl_i,
  output logic [N_LINKS-1:0]       stuff_o,
  output logic [N_LINKS-1:0]       ind_o
);
  localparam int unsigned PERIOD   = 1 << CNT_W;
  localparam int unsigned SCHED_PT = PERIOD - (LEAD_FRAMES + 1) * FRAME_CELLS;

  logic [LVL_W-1:0]   own_lvl [N_LINKS];
  logic [LVL_W-1:0]   ref_lvl;
  logic [N_LINKS-1:0] live, wrap, due, hi, lo, busy, is_ref;
  logic [N_LINKS-1:0] eval, self_load, load, mark, done_q;
  logic               fixed, ref_self;

  assign fixed    = (mode_i == MODE_CTC_FIX) || (mode_i == MODE_FIX_ALT);
  assign ref_lvl  = own_lvl[ref_sel_i];
  assign ref_self = self_load[ref_sel_i];

  for (genvar g = 0; g < N_LINKS; g++) begin : g_link
    assign own_lvl[g] = lvl_i[g*LVL_W +: LVL_W];
    assign is_ref[g]  = (ref_sel_i == REF_W'(g));

    ima_stuff_cell_ctr #(
      .CNT_W    (CNT_W),
      .SCHED_PT (SCHED_PT)
    ) u_ctr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .frame_i (frame_i[g]),
      .cell_i  (cell_i[g]),
      .live_o  (live[g]),
      .wrap_o  (wrap[g]),
      .due_o   (due[g])
    );

    ima_stuff_policy #(
      .LVL_W  (LVL_W),
      .THRESH (THRESH)
    ) u_pol (
      .own_lvl_i  (own_lvl[g]),
      .ref_lvl_i  (ref_lvl),
      .adaptive_i (~fixed),
      .is_ref_i   (is_ref[g]),
      .hi_o       (hi[g]),
      .lo_o       (lo[g])
    );

    assign eval[g]      = frame_i[g] & live[g] & ~busy[g] & ~done_q[g];
    assign self_load[g] = eval[g] & due[g];
    assign load[g]      = is_ref[g] ? self_load[g] :
                          fixed     ? (ref_self & frame_i[g] & live[g] & ~busy[g]) :
                                      (eval[g] & ((due[g] & ~hi[g]) | lo[g]));
    // skip also closes the period
    assign mark[g]      = load[g] | (eval[g] & due[g] & hi[g]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      done_q[g] <= 1'b0;
      else if (mark[g]) done_q[g] <= 1'b1;
      else if (wrap[g]) done_q[g] <= 1'b0;
    end

    ima_stuff_lookahead u_la (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .frame_i (frame_i[g]),
      .live_i  (live[g]),
      .load_i  (load[g]),
      .ind4_i  (ind4_i),
      .busy_o  (busy[g]),
      .stuff_o (stuff_o[g]),
      .ind_o   (ind_o[g])
    );
  end
endmodule

// File: rtl/ima_stuff_sched_chk.sv
module ima_stuff_sched_chk #(
  parameter int unsigned N_LINKS = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_LINKS-1:0] frame_i,
  input logic [N_LINKS-1:0] stuff_o,
  input logic [N_LINKS-1:0] ind_o
);
  logic [N_LINKS-1:0] seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= '0;
    else         seen_q <= seen_q | frame_i;
  end

  for (genvar g = 0; g < N_LINKS; g++) begin : g_chk
    assert_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !seen_q[g] |-> (!stuff_o[g] && !ind_o[g]));

    assert_exclusive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(stuff_o[g] && ind_o[g]));

    assert_announced_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(stuff_o[g]) |-> $past(ind_o[g]));

    assert_frame_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !frame_i[g] |=> ($stable(stuff_o[g]) && $stable(ind_o[g])));
  end
endmodule

bind ima_stuff_sched ima_stuff_sched_chk #(.N_LINKS(N_LINKS)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .frame_i (frame_i),
  .stuff_o (stuff_o),
  .ind_o   (ind_o)
);

// File: tb/sim_ima_stuff_sched.sv
module sim_ima_stuff_sched;
  localparam int unsigned N      = 4;
  localparam int unsigned CNT_W  = 6;
  localparam int unsigned FC     = 4;
  localparam int unsigned LVL_W  = 8;
  localparam int unsigned THRESH = 5;
  localparam int unsigned REF_W  = 2;
  localparam int          LAST_K = 32;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [N-1:0]     cell_i = '0;
  logic [N-1:0]     frame_i = '0;
  logic [1:0]       mode_i = '0;
  logic             ind4_i = 1'b0;
  logic [REF_W-1:0] ref_sel_i = '0;
  logic [N*LVL_W-1:0] lvl_i = '0;
  logic [N-1:0]     stuff_o, ind_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ima_stuff_sched #(
    .N_LINKS(N), .CNT_W(CNT_W), .FRAME_CELLS(FC), .LVL_W(LVL_W), .THRESH(THRESH)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cell_i(cell_i), .frame_i(frame_i),
    .mode_i(mode_i), .ind4_i(ind4_i), .ref_sel_i(ref_sel_i), .lvl_i(lvl_i),
    .stuff_o(stuff_o), .ind_o(ind_o)
  );

  task automatic chk(input bit got, input bit exp, input string tag, input int link, input int k);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s link%0d frame%0d actual=%0b expected=%0b", tag, link, k, got, exp);
    end
  endtask

  // frames at which a link schedules; scenario 2 link 1 is low (early), skip links never schedule
  function automatic bit is_load(input int scen, input int link, input int k);
    if (k < 1) return 1'b0;
    if (scen == 1 && link == 1) return 1'b0;
    if (scen == 2 && link == 3) return 1'b0;
    if (scen == 2 && link == 1) return (k == 1 || k == 16 || k == 32);
    return (k == 11 || k == 27);
  endfunction

  function automatic bit exp_stuff(input int scen, input int link, input int k);
    return is_load(scen, link, k - 4);
  endfunction

  function automatic bit exp_ind(input int scen, input int link, input int k, input bit four);
    if (!four) return is_load(scen, link, k - 3);
    for (int j = 0; j < 4; j++) if (is_load(scen, link, k - j)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [7:0] lvl_of(input int scen, input int link, input int k);
    case (scen)
      0: case (link) 0: return 8'd0; 1: return 8'd128; 2: return 8'd255; default: return 8'd3; endcase
      1: case (link) 0: return 8'd50; 1: return 8'd56; 2: return 8'd55; default: return 8'd45; endcase
      default: case (link)
        0: return 8'd100;
        1: return (k >= 2 && k <= 4) ? 8'd200 : 8'd94; // R9: high while committed
        2: return 8'd100;
        default: return 8'd106;
      endcase
    endcase
  endfunction

  function automatic string stuff_tag(input int scen, input int link, input int ref_l);
    if (scen == 0) return (link == ref_l) ? "R3" : "R6";
    if (scen == 1) return (link == 1) ? "R7" : (link == ref_l) ? "R2" : "R7_edge";
    if (link == 1) return "R8";
    return (link == ref_l) ? "R10" : "R2";
  endfunction

  task automatic do_reset();
    rst_ni = 1'b0; cell_i = '0; frame_i = '0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < N; i++) begin
      chk(stuff_o[i], 1'b0, "R1", i, -1);
      chk(ind_o[i], 1'b0, "R1", i, -1);
    end
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_scen(input int scen, input logic [1:0] mode, input bit four,
                          input int ref_l, input logic [N-1:0] mask, input int pre_cells);
    do_reset();
    mode_i = mode; ind4_i = four; ref_sel_i = REF_W'(ref_l);
    // R1: cells before the first frame strobe are not counted
    cell_i = '1;
    repeat (pre_cells) @(negedge clk);
    cell_i = '0;
    for (int k = 0; k <= LAST_K; k++) begin
      for (int i = 0; i < N; i++) lvl_i[i*LVL_W +: LVL_W] = lvl_of(scen, i, k);
      frame_i = '1;
      @(negedge clk);
      frame_i = '0;
      for (int i = 0; i < N; i++) begin
        chk(stuff_o[i], exp_stuff(scen, i, k), (k == 0) ? "R1" : stuff_tag(scen, i, ref_l), i, k);
        chk(ind_o[i], exp_ind(scen, i, k, four), (k == 0) ? "R1" : "R4", i, k);
      end
      cell_i = mask;
      repeat (FC - 1) @(negedge clk);
      @(negedge clk);
      cell_i = '0;
      for (int i = 0; i < N; i++) begin
        chk(stuff_o[i], exp_stuff(scen, i, k), "R5", i, k);
        chk(ind_o[i], exp_ind(scen, i, k, four), "R5", i, k);
      end
    end
  endtask

  // R6: fixed mode, link 0 has no cells and skewed levels yet follows the reference
  task automatic scen_fixed_four();
    run_scen(0, 2'd0, 1'b1, 1, 4'b1110, 20);
  endtask

  task automatic scen_fixed_alt_one();
    run_scen(0, 2'd3, 1'b0, 3, 4'b1110, 0);
  endtask

  // R7: link 1 six above reference skips, links at +5 and -5 stuff normally
  task automatic scen_ctc_adaptive();
    run_scen(1, 2'd1, 1'b1, 0, 4'b1111, 0);
  endtask

  // R8/R10: reference is link 2, link 1 low stuffs early, link 3 high skips
  task automatic scen_itc_adaptive();
    run_scen(2, 2'd2, 1'b1, 2, 4'b1111, 0);
  endtask

  initial begin
    scen_fixed_four();
    scen_fixed_alt_one();
    scen_ctc_adaptive();
    scen_itc_adaptive();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired, run incomplete (all requirements) actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule